// File: doc/BRIEF.md
# Programmable Tick Timer

This block is a processor tick timer with two 32-bit registers. One is a control word that holds a two-bit operating mode, an interrupt enable, a sticky interrupt pending flag and a period field. The other is a count register. Both are reached over a plain single-cycle register bus. Each pulse on the tick input advances the count by one. The tick rate is nominally 20 MHz and is produced outside this block.

A match occurs when the count, after an increment, has its low period-width bits equal to the period field. The upper count bits take no part in the compare. What happens on a match depends on the mode. Auto-restart clears the count. One-shot freezes the count until software writes the control word again. Continuous lets the count run on and wrap. If interrupts are enabled, a match also raises the pending flag. The level interrupt output is the AND of pending and enable.

Top module: `tt_tick_timer`

## Requirements
- R1: After reset, the control word and the count both read zero and `irq` is low.
- R2: `bus_addr` 0 selects the control word and 1 selects the count; `bus_rdata` shows the selected register combinationally. The control word lays out mode in bits [31:30], enable in bit 29, pending in bit 28 and period in bits [PERIOD_W-1:0]. The bits between period and pending always read zero.
- R3: Mode codes are 00 off, 01 auto-restart, 10 one-shot and 11 continuous. In any nonzero mode that is not frozen, each cycle with `tick_en` high adds one to the count. In mode 00 the count holds.
- R4: A match is a ticking cycle in which the low PERIOD_W bits of count+1 equal the period field. The count bits above PERIOD_W are ignored.
- R5: A match with enable set sets pending. A match with enable clear leaves pending unchanged. `irq` equals pending AND enable.
- R6: Pending is sticky. A control write loads it from bit 28, so writing 0 clears it, but a match in the same cycle sets it anyway.
- R7: In auto-restart mode, a match loads the count with zero.
- R8: In one-shot mode, a match stores count+1 and then freezes the count. Any later control-word write releases the freeze.
- R9: In continuous mode, a match stores count+1 and counting goes on, so the next match comes 2^PERIOD_W ticks later.
- R10: A count write in the same cycle as a tick stores the written value and suppresses both the increment and any match action, pending included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 count |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the selected register |
| tick_en | input | 1 | One timer tick per high cycle |
| irq | output | 1 | Level timer interrupt request |

## Verification
The bench builds the timer with DATA_W at 32 and PERIOD_W at 8. The narrow period field lets a continuous-mode rollover of 256 ticks finish in a short run. It also lets a count written as 0x102 show that upper bits stay out of the compare. With only eight period bits, bits 27:8 of the control word become unused, so the bench can also check that they read zero after an all-ones write.

// File: rtl/tt_pkg.sv
package tt_pkg;

    typedef enum logic [1:0] {
        TT_OFF     = 2'b00,
        TT_RESTART = 2'b01,
        TT_ONESHOT = 2'b10,
        TT_FREERUN = 2'b11
    } tt_mode_e;

    typedef enum logic {
        TT_SEL_CTRL  = 1'b0,
        TT_SEL_COUNT = 1'b1
    } tt_sel_e;

    typedef struct packed {
        tt_mode_e mode;
        logic     ie;
        logic     ip;
    } tt_flags_t;

    localparam int TT_FLAG_BITS = 4;

    function automatic logic tt_mode_runs(tt_mode_e m);
        return m != TT_OFF;
    endfunction

endpackage

// File: rtl/tt_ctrl_reg.sv
module tt_ctrl_reg
    import tt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PERIOD_W = 28
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                hit,
    output tt_flags_t           flags_q,
    output logic [PERIOD_W-1:0] period_q
);
    localparam int FLAG_LSB = DATA_W - TT_FLAG_BITS;

    tt_flags_t           flags_d;
    logic [PERIOD_W-1:0] period_d;

    always_comb begin
        flags_d  = flags_q;
        period_d = period_q;
        if (wr_en) begin
            flags_d.mode = tt_mode_e'(wdata[DATA_W-1 -: 2]);
            flags_d.ie   = wdata[DATA_W-3];
            flags_d.ip   = wdata[FLAG_LSB];
            period_d     = wdata[PERIOD_W-1:0];
        end
        if (hit && flags_q.ie) begin
            flags_d.ip = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q  <= '{mode: TT_OFF, ie: 1'b0, ip: 1'b0};
            period_q <= '0;
        end else begin
            flags_q  <= flags_d;
            period_q <= period_d;
        end
    end

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (flags_q.ip && !wr_en) |=> flags_q.ip);

    p_set_on_hit_r5: assert property (@(posedge clk) disable iff (rst)
        (hit && flags_q.ie) |=> flags_q.ip);

    p_no_set_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (!flags_q.ip && !flags_q.ie && !wr_en) |=> !flags_q.ip);

endmodule

// File: rtl/tt_match.sv
module tt_match #(
    parameter int DATA_W   = 32,
    parameter int PERIOD_W = 28
) (
    input  logic [DATA_W-1:0]   cnt_q,
    input  logic [PERIOD_W-1:0] period,
    input  logic                tick,
    input  logic                running,
    input  logic                cnt_wr,
    output logic [DATA_W-1:0]   cnt_inc,
    output logic                hit
);
    logic advance;

    assign cnt_inc = cnt_q + DATA_W'(1);
    assign advance = tick && running && !cnt_wr;
    assign hit     = advance && (cnt_inc[PERIOD_W-1:0] == period);

endmodule

// File: rtl/tt_counter.sv
module tt_counter
    import tt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    input  logic              hit,
    input  logic [DATA_W-1:0] cnt_inc,
    input  tt_mode_e          mode,
    input  logic              mode_wr,
    output logic [DATA_W-1:0] cnt_q,
    output logic              running
);
    logic              frozen_q;
    logic              frozen_d;
    logic [DATA_W-1:0] cnt_d;

    assign running = tt_mode_runs(mode) && !frozen_q;

    always_comb begin
        frozen_d = frozen_q;
        if (mode_wr) begin
            frozen_d = 1'b0;
        end else if (hit && mode == TT_ONESHOT) begin
            frozen_d = 1'b1;
        end
    end

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_wr) begin
            cnt_d = wdata;
        end else if (running && tick) begin
            if (hit && mode == TT_RESTART) begin
                cnt_d = '0;
            end else begin
                cnt_d = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            frozen_q <= 1'b0;
        end else begin
            cnt_q    <= cnt_d;
            frozen_q <= frozen_d;
        end
    end

    p_off_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == TT_OFF && !cnt_wr) |=> cnt_q == $past(cnt_q));

    p_frozen_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && !cnt_wr) |=> cnt_q == $past(cnt_q));

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && mode == TT_RESTART) |=> cnt_q == '0);

    p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> cnt_q == $past(wdata));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && running && !cnt_wr && !(hit && mode == TT_RESTART))
        |=> cnt_q == $past(cnt_q) + DATA_W'(1));

endmodule

// File: rtl/tt_tick_timer.sv
module tt_tick_timer
    import tt_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int PERIOD_W = 28
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    output logic              irq
);
    localparam int FLAG_LSB = DATA_W - TT_FLAG_BITS;

    tt_flags_t           flags;
    logic [PERIOD_W-1:0] period;
    logic [DATA_W-1:0]   cnt;
    logic [DATA_W-1:0]   cnt_inc;
    logic                running;
    logic                hit;
    logic                ctrl_wr;
    logic                cnt_wr;

    assign ctrl_wr = bus_we && (tt_sel_e'(bus_addr) == TT_SEL_CTRL);
    assign cnt_wr  = bus_we && (tt_sel_e'(bus_addr) == TT_SEL_COUNT);

    tt_ctrl_reg #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (ctrl_wr),
        .wdata    (bus_wdata),
        .hit      (hit),
        .flags_q  (flags),
        .period_q (period)
    );

    tt_match #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_match (
        .cnt_q   (cnt),
        .period  (period),
        .tick    (tick_en),
        .running (running),
        .cnt_wr  (cnt_wr),
        .cnt_inc (cnt_inc),
        .hit     (hit)
    );

    tt_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .cnt_wr  (cnt_wr),
        .wdata   (bus_wdata),
        .tick    (tick_en),
        .hit     (hit),
        .cnt_inc (cnt_inc),
        .mode    (flags.mode),
        .mode_wr (ctrl_wr),
        .cnt_q   (cnt),
        .running (running)
    );

    always_comb begin
        bus_rdata = '0;
        if (tt_sel_e'(bus_addr) == TT_SEL_COUNT) begin
            bus_rdata = cnt;
        end else begin
            bus_rdata[DATA_W-1 -: 2]  = flags.mode;
            bus_rdata[DATA_W-3]       = flags.ie;
            bus_rdata[FLAG_LSB]       = flags.ip;
            bus_rdata[PERIOD_W-1:0]   = period;
        end
    end

    assign irq = flags.ip && flags.ie;

    p_irq_drop_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !bus_wdata[DATA_W-3]) |=> !irq);

endmodule

// File: tb/tt_tick_timer_tb.sv
`timescale 1ns/1ps
module tt_tick_timer_tb;

    localparam int DATA_W   = 32;
    localparam int PERIOD_W = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic              bus_addr = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              tick_en = 1'b0;
    logic              irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tt_tick_timer #(.DATA_W(DATA_W), .PERIOD_W(PERIOD_W)) u_dut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_en(tick_en), .irq(irq)
    );

    typedef struct packed {
        logic        we;
        logic        addr;
        logic        tick;
        logic [31:0] wdata;
        logic [31:0] exp_cnt;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b0}, // R3 off holds
        '{1'b1, 1'b0, 1'b0, 32'h6000_0003, 32'h0000_0000, 1'b0}, // restart, ie, period 3
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0001, 1'b0}, // R3
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0002, 1'b0}, // R3
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R7 R5
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0001, 1'b1}, // R6 sticky
        '{1'b1, 1'b0, 1'b0, 32'h6000_0003, 32'h0000_0001, 1'b0}, // R6 clear
        '{1'b1, 1'b1, 1'b1, 32'h0000_0102, 32'h0000_0102, 1'b0}, // R10
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0000, 1'b1}, // R4 upper bits ignored
        '{1'b1, 1'b0, 1'b0, 32'hA000_0002, 32'h0000_0000, 1'b0}, // one-shot period 2
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0001, 1'b0}, // R3
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0002, 1'b1}, // R8 match
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0002, 1'b1}, // R8 frozen
        '{1'b1, 1'b0, 1'b0, 32'hA000_0004, 32'h0000_0002, 1'b0}, // R8 release
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0003, 1'b0}, // R8 resumed
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0004, 1'b1}, // R8 second stop
        '{1'b1, 1'b0, 1'b0, 32'hC000_0005, 32'h0000_0004, 1'b0}, // continuous, ie off
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, 32'h0000_0005, 1'b0}  // R5 masked match
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic we, input logic addr, input logic [31:0] wd, input logic tk);
        @(negedge clk);
        bus_we = we; bus_addr = addr; bus_wdata = wd; tick_en = tk;
        @(posedge clk);
        #1;
        bus_we = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic addr, output logic [31:0] val);
        bus_addr = addr;
        #1;
        val = bus_rdata;
    endtask

    initial begin
        #(5ns * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        rd(1'b0, v); check("R1 ctrl", v, 32'h0);
        rd(1'b1, v); check("R1 count", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].we, VEC[i].addr, VEC[i].wdata, VEC[i].tick);
            rd(1'b1, v);
            check($sformatf("R3/R4/R7/R8/R10 vec%0d count", i), v, VEC[i].exp_cnt);
            check($sformatf("R5/R6 vec%0d irq", i), {31'b0, irq}, {31'b0, VEC[i].exp_irq});
        end

        rd(1'b0, v); check("R5 no pending when masked", v, 32'hC000_0005);

        // R9: continuous rollover of the low eight bits
        step(1'b1, 1'b0, 32'hE000_0005, 1'b0);
        for (int t = 0; t < 255; t++) step(1'b0, 1'b0, 32'h0, 1'b1);
        check("R9 no early match", {31'b0, irq}, 32'h0);
        rd(1'b1, v); check("R9 count before wrap match", v, 32'h0000_0104);
        step(1'b0, 1'b0, 32'h0, 1'b1);
        check("R9 match after full rollover", {31'b0, irq}, 32'h1);
        rd(1'b1, v); check("R9 count keeps running", v, 32'h0000_0105);
        rd(1'b0, v); check("R2 ctrl readback pending", v, 32'hF000_0005);

        // R2: unused control bits read zero
        step(1'b1, 1'b0, 32'hFFFF_FFFF, 1'b0);
        rd(1'b0, v); check("R2 unused bits zero", v, 32'hF000_00FF);
        check("R5 irq pending and enabled", {31'b0, irq}, 32'h1);

        // R3: mode off holds count
        step(1'b1, 1'b0, 32'h0000_0000, 1'b0);
        check("R6 write zero clears irq", {31'b0, irq}, 32'h0);
        step(1'b0, 1'b0, 32'h0, 1'b1);
        step(1'b0, 1'b0, 32'h0, 1'b1);
        rd(1'b1, v); check("R3 off mode holds", v, 32'h0000_0105);

        // R1: reset mid-run
        step(1'b1, 1'b0, 32'h7000_0009, 1'b0);
        check("R6 write one sets pending", {31'b0, irq}, 32'h1);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
        #1;
        rd(1'b0, v); check("R1 ctrl after reset", v, 32'h0);
        rd(1'b1, v); check("R1 count after reset", v, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule